// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

A purely combinational 64-bit add/subtract datapath whose internal carry chain is split into 8-bit segments. A run-time lane-width select joins the segments into eight 8-bit, four 16-bit, two 32-bit or one 64-bit lane. No carry passes between lanes. Every lane adds or subtracts its own slice of the two operands. Subtraction inverts the second operand and injects a 1 as the lane's carry-in.

A signed/unsigned select sets how each lane detects overflow. A saturate enable sets what an overflowing lane returns. With saturation off, the lane wraps modulo 2^n. With saturation on, the lane clamps to the limit of its range in the direction of the overflow. A per-lane overflow flag is always driven, whatever the saturate setting. Media kernels use the block for packed pixel and sample arithmetic, where clipping replaces wrap-around.

Top module: `simd_sat_add`

## Requirements
- R1: `lane_mode_i` selects the lane width: 0 gives 8-bit, 1 gives 16-bit, 2 gives 32-bit and 3 gives 64-bit lanes. Lane i occupies result bits [i*w +: w]. No carry or borrow passes from one lane into the next.
- R2: With `lane_mode_i`=3, the full 64-bit carry chain is connected and the block acts as one 64-bit adder/subtractor.
- R3: With `sub_i`=1, each lane computes a minus b modulo 2^w, using the inverted b plus a carry-in of 1.
- R4: Signed addition (`signed_i`=1, `sub_i`=0) flags a lane only when both operands have the same sign and the result sign differs from it. Operands of opposite sign never flag.
- R5: Signed subtraction flags a lane only when the operand signs differ. A non-negative minus a negative flags when the result sign is 1. A negative minus a non-negative flags when the result sign is 0.
- R6: Unsigned lanes flag a carry out of the lane MSB on addition, and a borrow (a < b) on subtraction.
- R7: With `sat_i`=1 and `signed_i`=1, an overflowing lane returns 0x7F..F when the first operand is non-negative and 0x80..0 when it is negative.
- R8: With `sat_i`=1 and `signed_i`=0, an overflowing lane returns all ones on addition and all zeros on subtraction.
- R9: With `sat_i`=0, an overflowing lane returns its wrapped result and still raises its flag.
- R10: `ovf_o[i]` is the flag of lane i. Bits at or above the lane count for the selected mode are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand, packed lanes |
| b_i | input | 64 | Second operand, packed lanes |
| lane_mode_i | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64 bits) |
| sub_i | input | 1 | 1 = a minus b, 0 = a plus b |
| signed_i | input | 1 | 1 = two's complement lanes, 0 = unsigned lanes |
| sat_i | input | 1 | 1 = clamp on overflow, 0 = wrap |
| sum_o | output | 64 | Packed per-lane result |
| ovf_o | output | 8 | Per-lane overflow flag, lane 0 in bit 0 |

## Verification
The hardest situation to reach is a carry that would cross a lane boundary: a lane must be all ones on addition, or must borrow on subtraction, while its upper neighbour holds a value where a leaked carry would show. Clamps confined to a middle lane are similarly rare. Uniform random operands seldom produce either pattern. The stimulus therefore builds operands byte by byte, drawing many bytes from 0x00, 0x01, 0x7F, 0x80 and 0xFF. This creates carry and borrow chains that stop at every segment edge in all four lane modes. Directed vectors then fix the extreme cases for each mode, signedness and saturate setting.

// File: rtl/simd_sat_add_pkg.sv
package simd_sat_add_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned SEG_W  = 8;
  localparam int unsigned N_SEG  = DATA_W / SEG_W;
  localparam int unsigned IDX_W  = $clog2(N_SEG);
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/simd_lane_ctl.sv
module simd_lane_ctl #(
  parameter int unsigned N_SEG  = 8,
  parameter int unsigned MODE_W = 2,
  localparam int unsigned IDX_W = $clog2(N_SEG)
) (
  input  logic [MODE_W-1:0]           mode_i,
  output logic [N_SEG-1:0]            first_o,
  output logic [N_SEG-1:0]            last_o,
  output logic [N_SEG-1:0][IDX_W-1:0] msb_idx_o
);
  int unsigned span;

  always_comb begin
    span = 1 << mode_i;
    if (span > N_SEG) span = N_SEG;
    for (int unsigned k = 0; k < N_SEG; k++) begin
      first_o[k]   = (k % span) == 0;
      last_o[k]    = (k % span) == span - 1;
      msb_idx_o[k] = IDX_W'(k | (span - 1));
    end
  end
endmodule

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o,
  output logic         sovf_o,
  output logic         uovf_o
);
  logic [W-1:0] b_eff;
  logic         c_msb;

  always_comb begin
    b_eff       = sub_i ? ~b_i : b_i;
    {co_o, s_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, ci_i};
    // carry into the top bit recovered from the sum bit
    c_msb       = a_i[W-1] ^ b_eff[W-1] ^ s_o[W-1];
    sovf_o      = c_msb ^ co_o;
    // add: carry out; sub: missing carry means borrow
    uovf_o      = co_o ^ sub_i;
  end
endmodule

// File: rtl/simd_sat_sel.sv
module simd_sat_sel #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] raw_i,
  input  logic         lane_ovf_i,
  input  logic         lane_neg_i,
  input  logic         is_msb_i,
  input  logic         sat_i,
  input  logic         signed_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] clamp;

  always_comb begin
    if (signed_i) begin
      if (lane_neg_i) clamp = is_msb_i ? {1'b1, {(W-1){1'b0}}} : '0;
      else            clamp = is_msb_i ? {1'b0, {(W-1){1'b1}}} : '1;
    end else begin
      clamp = sub_i ? '0 : '1;
    end
    res_o = (sat_i && lane_ovf_i) ? clamp : raw_i;
  end
endmodule

// File: rtl/simd_sat_add.sv
module simd_sat_add
  import simd_sat_add_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [MODE_W-1:0] lane_mode_i,
  input  logic              sub_i,
  input  logic              signed_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [N_SEG-1:0]  ovf_o
);
  logic [N_SEG-1:0]            first, last;
  logic [N_SEG-1:0][IDX_W-1:0] msb_idx;
  logic [N_SEG:0]              carry;
  logic [N_SEG-1:0]            sovf, uovf, seg_ovf, seg_ci;
  logic [N_SEG-1:0][SEG_W-1:0] raw;
  lane_mode_e                  mode;

  assign mode     = lane_mode_e'(lane_mode_i);
  assign carry[0] = sub_i;

  simd_lane_ctl #(.N_SEG(N_SEG), .MODE_W(MODE_W)) i_lane_ctl (
    .mode_i    (mode),
    .first_o   (first),
    .last_o    (last),
    .msb_idx_o (msb_idx)
  );

  for (genvar k = 0; k < N_SEG; k++) begin : g_seg
    // lane start takes the subtract carry-in, otherwise the chain
    assign seg_ci[k] = first[k] ? sub_i : carry[k];

    simd_seg_add #(.W(SEG_W)) i_seg (
      .a_i    (a_i[k*SEG_W +: SEG_W]),
      .b_i    (b_i[k*SEG_W +: SEG_W]),
      .sub_i  (sub_i),
      .ci_i   (seg_ci[k]),
      .s_o    (raw[k]),
      .co_o   (carry[k+1]),
      .sovf_o (sovf[k]),
      .uovf_o (uovf[k])
    );

    assign seg_ovf[k] = signed_i ? sovf[k] : uovf[k];

    simd_sat_sel #(.W(SEG_W)) i_sat (
      .raw_i      (raw[k]),
      .lane_ovf_i (seg_ovf[msb_idx[k]]),
      .lane_neg_i (a_i[msb_idx[k]*SEG_W + SEG_W - 1]),
      .is_msb_i   (last[k]),
      .sat_i      (sat_i),
      .signed_i   (signed_i),
      .sub_i      (sub_i),
      .res_o      (sum_o[k*SEG_W +: SEG_W])
    );
  end

  int unsigned span;
  always_comb begin
    span  = 1 << lane_mode_i;
    ovf_o = '0;
    for (int unsigned i = 0; i < N_SEG; i++) begin
      if (i < N_SEG / span) ovf_o[i] = seg_ovf[IDX_W'(i * span + span - 1)];
    end
  end
endmodule

// File: rtl/simd_sat_add_chk.sv
module simd_sat_add_chk (
  input logic [63:0] a_i,
  input logic [63:0] b_i,
  input logic [1:0]  lane_mode_i,
  input logic        sub_i,
  input logic        signed_i,
  input logic        sat_i,
  input logic [63:0] sum_o,
  input logic [7:0]  ovf_o
);
  logic [7:0] lo_wrap;
  assign lo_wrap = sub_i ? (a_i[7:0] - b_i[7:0]) : (a_i[7:0] + b_i[7:0]);

  always_comb begin
    assert_unused_flags_R10: assert (
      (lane_mode_i == 2'd0) ||
      (lane_mode_i == 2'd1 && ovf_o[7:4] == 4'd0) ||
      (lane_mode_i == 2'd2 && ovf_o[7:2] == 6'd0) ||
      (lane_mode_i == 2'd3 && ovf_o[7:1] == 7'd0));
    assert_wrap_low_R9: assert (sat_i || lane_mode_i != 2'd0 || sum_o[7:0] == lo_wrap);
    assert_no_overflow_R4: assert (!(signed_i && !sub_i && lane_mode_i == 2'd0 &&
                                     a_i[7] != b_i[7] && ovf_o[0]));
    assert_no_overflow_R5: assert (!(signed_i && sub_i && lane_mode_i == 2'd0 &&
                                     a_i[7] == b_i[7] && ovf_o[0]));
    assert_signed_clamp_R7: assert (!(sat_i && signed_i && lane_mode_i == 2'd0 && ovf_o[0]) ||
                                    sum_o[7:0] == (a_i[7] ? 8'h80 : 8'h7F));
    assert_unsigned_clamp_R8: assert (!(sat_i && !signed_i && lane_mode_i == 2'd0 && ovf_o[0]) ||
                                      sum_o[7:0] == (sub_i ? 8'h00 : 8'hFF));
  end
endmodule

bind simd_sat_add simd_sat_add_chk i_chk (
  .a_i         (a_i),
  .b_i         (b_i),
  .lane_mode_i (lane_mode_i),
  .sub_i       (sub_i),
  .signed_i    (signed_i),
  .sat_i       (sat_i),
  .sum_o       (sum_o),
  .ovf_o       (ovf_o)
);

// File: tb/test_simd_sat_add.sv
module test_simd_sat_add;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] a, b, sum;
  logic [1:0]  mode;
  logic        sub, sgn, sat;
  logic [7:0]  ovf;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  simd_sat_add i_simd_sat_add (
    .a_i(a), .b_i(b), .lane_mode_i(mode), .sub_i(sub),
    .signed_i(sgn), .sat_i(sat), .sum_o(sum), .ovf_o(ovf)
  );

  function automatic void model(input logic [63:0] xa, xb, input logic [1:0] m,
                                input logic s, g, t,
                                output logic [63:0] r, output logic [7:0] f);
    int w = 8 << m;
    int n = 64 / w;
    r = '0; f = '0;
    for (int i = 0; i < n; i++) begin
      logic [65:0] x, y, full, mask, lane;
      logic signed [65:0] top;
      logic ov;
      mask = (66'd1 << w) - 66'd1;
      x = ({2'b0, xa} >> (i * w)) & mask;
      y = ({2'b0, xb} >> (i * w)) & mask;
      if (g) begin
        if (x[w-1]) x = x | ~mask;
        if (y[w-1]) y = y | ~mask;
      end
      full = s ? x - y : x + y;
      if (g) begin
        top = $signed(full) >>> (w - 1);
        ov  = !(top == 0 || top == -1);
      end else begin
        ov = s ? (x < y) : ((full >> w) != 0);
      end
      lane = full & mask;
      if (ov && t)
        lane = g ? (x[w-1] ? (66'd1 << (w - 1)) : ((66'd1 << (w - 1)) - 66'd1))
                 : (s ? 66'd0 : mask);
      r = r | (64'(lane) << (i * w));
      f[i] = ov;
    end
  endfunction

  function automatic string auto_tag(input logic [1:0] m, input logic s, g, t,
                                     input logic [7:0] f);
    if (f != 0 && t) return g ? "R7" : "R8";
    if (f != 0)      return "R9";
    if (m == 2'd3)   return "R2";
    if (s)           return "R3";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [63:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h (a=%h b=%h mode=%0d sub=%0b sgn=%0b sat=%0b)",
               req, act, exp, a, b, mode, sub, sgn, sat);
    end
  endtask

  task automatic run(input logic [63:0] xa, xb, input logic [1:0] m,
                     input logic s, g, t, input string tag);
    logic [63:0] er;
    logic [7:0]  ef;
    string       ftag;
    @(negedge clk);
    a = xa; b = xb; mode = m; sub = s; sgn = g; sat = t;
    #1;
    model(xa, xb, m, s, g, t, er, ef);
    check(tag == "" ? auto_tag(m, s, g, t, ef) : tag, sum, er);
    ftag = g ? (s ? "R5" : "R4") : "R6";
    check(ftag, {56'd0, ovf}, {56'd0, ef});
    check("R10", {56'd0, ovf & ~((8'd1 << (8 >> m)) - 8'd1)}, 64'd0);
  endtask

  function automatic logic [63:0] pick_op();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) begin
      case ($urandom % 8)
        0: v[k*8 +: 8] = 8'h00;
        1: v[k*8 +: 8] = 8'h01;
        2: v[k*8 +: 8] = 8'h7F;
        3: v[k*8 +: 8] = 8'h80;
        4: v[k*8 +: 8] = 8'hFF;
        default: v[k*8 +: 8] = 8'($urandom);
      endcase
    end
    return v;
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    a = '0; b = '0; mode = '0; sub = 0; sgn = 0; sat = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle inputs give zero outputs
    run(64'd0, 64'd0, 2'd0, 0, 0, 0, "R1");
    // R1: carries stop at every byte edge
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 0, 0, 0, "R1");
    run(64'h00FF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'd1, 0, 0, 0, "R1");
    run(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd2, 0, 0, 0, "R1");
    // R2: full chain
    run(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 0, 0, 0, "R2");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 0, 0, 0, "R2");
    // R3: borrow does not leak
    run(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'd0, 1, 0, 0, "R3");
    run(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'd1, 1, 1, 0, "R3");
    // R4/R5 signed edges
    run(64'h7F80_7F80_0000_0000, 64'h0180_8001_0000_0000, 2'd0, 0, 1, 0, "R4");
    run(64'h7F80_7F80_0000_0000, 64'hFF01_8000_0000_0000, 2'd0, 1, 1, 0, "R5");
    // R6 unsigned carry / borrow
    run(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'd3, 0, 0, 0, "R6");
    // R7 signed clamp in a middle lane only
    run(64'h0000_7FFF_8000_0000, 64'h0000_0001_FFFF_0000, 2'd1, 0, 1, 1, "R7");
    run(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 2'd2, 0, 1, 1, "R7");
    run(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1, 1, 1, "R7");
    // R8 unsigned clamp
    run(64'hFF00_FF00_FF00_FF00, 64'h0101_0101_0101_0101, 2'd0, 0, 0, 1, "R8");
    run(64'h0000_0001_0000_0005, 64'h0000_0002_0000_0003, 2'd2, 1, 0, 1, "R8");
    // R9 wrap with flag
    run(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 0, 1, 0, "R9");
    for (int i = 0; i < 3000; i++)
      run(pick_op(), pick_op(), 2'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), "");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule